// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block manages clocks and reset for a small 8-bit microcontroller core. It counts how long the external reset pin stays high. It raises the internal reset only after the pin has held for two full machine cycles, so short glitches never reset the core. It also runs the core's low-power states. Software asks for them through two request bits. A rising edge on the idle request stops the CPU clock and leaves the peripheral clock running. A rising edge on the power-down request stops both clocks and turns the oscillator off.

The two low-power states wake up differently:

- Idle ends when an enabled interrupt is pending, or when the reset pin goes high.
- Power-down ends only through a full internal reset.

When the reset pin ends idle, the CPU clock restarts at once. The core may then run for a short time before the internal reset takes over. During that time a RAM write-inhibit output blocks writes to on-chip RAM, while port writes are still allowed.

The block also holds a copy of the external-access strap. When the lock bit is set, the core sees the strap level captured during the last reset. When the lock bit is clear, the core sees the live pin. The block runs on the oscillator clock and samples every input on its rising edge.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: The internal reset goes high after the 24th consecutive rising edge at which the reset pin is sampled high (two machine cycles of 12 oscillator periods). It is low after 23 such edges.
- R2: One low sample of the reset pin restarts the count from zero. After the first edge at which the pin is sampled low, the internal reset is low.
- R3: In run state, a rising edge on the idle request enters idle after one clock edge. In idle the CPU clock enable is 0, and the peripheral clock enable and oscillator enable are both 1.
- R4: In idle, a pending interrupt sampled at an edge restores the CPU clock enable to 1 after that edge.
- R5: In run state, a rising edge on the power-down request sets the CPU clock, peripheral clock and oscillator enables to 0 after one edge. A pending interrupt does not change any of them.
- R6: In power-down, the oscillator enable follows a high reset pin at once, without waiting for a clock edge. Both clock enables stay 0 through the edge at which the internal reset first goes high. They return to 1 after the next edge.
- R7: If both requests rise at the same edge, the block enters power-down, so the peripheral clock enable is 0.
- R8: In idle, a high reset pin sampled at an edge sets the CPU clock enable and the RAM write inhibit to 1 after that edge. This takes priority over a pending interrupt at the same edge. The inhibit stays 1 until the edge after the internal reset goes high, or until the pin is sampled low. Outside this window the inhibit is 0.
- R9: The external-access strap is captured at every edge at which the internal reset is high. With the lock bit at 1, the strap output shows that captured value. With the lock bit at 0, it shows the live pin.
- R10: Requests seen while the internal reset is high are ignored. A request level held through a reset does not enter a low-power state afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Software idle request bit |
| pd_req | input | 1 | Software power-down request bit |
| irq_pend | input | 1 | An enabled interrupt is pending |
| lock1 | input | 1 | Lock bit that selects the captured strap |
| ea_pin | input | 1 | External-access strap pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| rst_int | output | 1 | Filtered internal reset |
| ram_wr_inh | output | 1 | Blocks on-chip RAM writes |
| ea_latched | output | 1 | External-access level seen by the core |

## Verification
In idle, a pending interrupt and a rising reset pin can be sampled at the same edge. Each one alone would wake the CPU, but only the reset wake raises the RAM write inhibit. The bench provokes this by raising both inputs in the same cycle while the block is idle. It judges the result by checking, after that edge, that the CPU clock is running and the inhibit is high.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2,
    MODE_WAKE = 2'd3
  } pmode_e;
endpackage

// File: rtl/prc_rst_filter.sv
module prc_rst_filter #(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2
) (
  input  logic clk,
  input  logic pin,
  output logic rst_out
);
  localparam int TOTAL = OSC_PER_MC * HOLD_MC;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOTAL);

  logic [CW-1:0] cnt_q;

  // consecutive-high counter, saturating at the limit
  always_ff @(posedge clk) begin
    if (!pin)
      cnt_q <= '0;
    else if (cnt_q != LIMIT)
      cnt_q <= cnt_q + 1'b1;
  end

  assign rst_out = (cnt_q == LIMIT);
endmodule

// File: rtl/prc_mode_fsm.sv
module prc_mode_fsm
  import pwr_rst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_int,
  input  logic   rst_pin,
  input  logic   idle_req,
  input  logic   pd_req,
  input  logic   irq_pend,
  output pmode_e mode
);
  logic idle_q, pd_q;
  logic idle_rise, pd_rise;

  assign idle_rise = idle_req & ~idle_q;
  assign pd_rise   = pd_req & ~pd_q;

  always_ff @(posedge clk) begin
    idle_q <= idle_req;
    pd_q   <= pd_req;
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      mode <= MODE_RUN;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (pd_rise)        mode <= MODE_PD;
          else if (idle_rise) mode <= MODE_IDLE;
        end
        MODE_IDLE: begin
          if (rst_pin)        mode <= MODE_WAKE;
          else if (irq_pend)  mode <= MODE_RUN;
        end
        MODE_PD:   mode <= MODE_PD;
        MODE_WAKE: begin
          if (!rst_pin)       mode <= MODE_RUN;
        end
        default:   mode <= MODE_RUN;
      endcase
    end
  end
endmodule

// File: rtl/prc_ea_hold.sv
module prc_ea_hold (
  input  logic clk,
  input  logic rst_int,
  input  logic lock,
  input  logic ea_pin,
  output logic ea_out
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst_int)
      hold_q <= ea_pin;
  end

  assign ea_out = lock ? hold_q : ea_pin;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_rst_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2
) (
  input  logic clk_osc,
  input  logic rst_pin,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pend,
  input  logic lock1,
  input  logic ea_pin,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic rst_int,
  output logic ram_wr_inh,
  output logic ea_latched
);
  pmode_e mode;

  prc_rst_filter #(.OSC_PER_MC(OSC_PER_MC), .HOLD_MC(HOLD_MC)) u_filt (
    .clk     (clk_osc),
    .pin     (rst_pin),
    .rst_out (rst_int)
  );

  prc_mode_fsm u_fsm (
    .clk      (clk_osc),
    .rst_int  (rst_int),
    .rst_pin  (rst_pin),
    .idle_req (idle_req),
    .pd_req   (pd_req),
    .irq_pend (irq_pend),
    .mode     (mode)
  );

  prc_ea_hold u_ea (
    .clk     (clk_osc),
    .rst_int (rst_int),
    .lock    (lock1),
    .ea_pin  (ea_pin),
    .ea_out  (ea_latched)
  );

  assign cpu_clk_en = (mode == MODE_RUN) || (mode == MODE_WAKE);
  assign per_clk_en = (mode != MODE_PD);
  assign osc_en     = (mode != MODE_PD) || rst_pin;
  assign ram_wr_inh = (mode == MODE_WAKE);
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic clk_osc,
  input logic rst_pin,
  input logic idle_req,
  input logic pd_req,
  input logic rst_int,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic ram_wr_inh
);
  logic armed = 1'b0;

  always_ff @(posedge clk_osc) begin
    if (rst_int) armed <= 1'b1;
  end

  AST_RESET_NEEDS_PIN: assert property (@(posedge clk_osc) disable iff (!armed)
    $rose(rst_int) |-> $past(rst_pin)); // R1

  AST_LOW_PIN_CLEARS: assert property (@(posedge clk_osc) disable iff (!armed)
    !rst_pin |=> !rst_int); // R2

  AST_SLEEP_FROM_REQ: assert property (@(posedge clk_osc) disable iff (!armed || rst_int)
    $fell(cpu_clk_en) |-> $past(idle_req || pd_req)); // R3

  AST_PD_HOLDS: assert property (@(posedge clk_osc) disable iff (!armed)
    (!per_clk_en && !rst_int) |=> !per_clk_en); // R5

  AST_INHIBIT_FROM_IDLE: assert property (@(posedge clk_osc) disable iff (!armed || rst_int)
    $rose(ram_wr_inh) |-> $past(!cpu_clk_en && per_clk_en)); // R8

  AST_INHIBIT_RUNS_CPU: assert property (@(posedge clk_osc) disable iff (!armed)
    ram_wr_inh |-> cpu_clk_en); // R8
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk u_chk (
  .clk_osc    (clk_osc),
  .rst_pin    (rst_pin),
  .idle_req   (idle_req),
  .pd_req     (pd_req),
  .rst_int    (rst_int),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .ram_wr_inh (ram_wr_inh)
);

// File: tb/tb_pwr_rst_ctrl.sv
module tb_pwr_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 24;

  logic clk_osc = 1'b0;
  logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0;
  logic lock1 = 1'b0, ea_pin = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, rst_int, ram_wr_inh, ea_latched;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  pwr_rst_ctrl dut (
    .clk_osc(clk_osc), .rst_pin(rst_pin), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pend(irq_pend), .lock1(lock1), .ea_pin(ea_pin),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .rst_int(rst_int), .ram_wr_inh(ram_wr_inh), .ea_latched(ea_latched)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_osc);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic pulse_reset();
    rst_pin = 1'b1;
    step(FILT);
    rst_pin = 1'b0;
    step(1);
  endtask

  task automatic t_reset_state();
    rst_pin = 1'b1;
    step(FILT - 1);
    chk("R1", "rst_int after 23", rst_int, 1'b0);
    step(1);
    chk("R1", "rst_int after 24", rst_int, 1'b1);
    rst_pin = 1'b0;
    step(1);
    chk("R2", "rst_int after low", rst_int, 1'b0);
    chk("R1", "cpu_clk_en run", cpu_clk_en, 1'b1);
    chk("R1", "per_clk_en run", per_clk_en, 1'b1);
    chk("R1", "osc_en run", osc_en, 1'b1);
    chk("R8", "ram_wr_inh run", ram_wr_inh, 1'b0);
  endtask

  task automatic t_glitch_filter();
    rst_pin = 1'b1;
    step(FILT - 1);
    rst_pin = 1'b0;
    step(1);
    rst_pin = 1'b1;
    step(FILT - 1);
    chk("R2", "count restarted", rst_int, 1'b0);
    step(1);
    chk("R1", "full count after restart", rst_int, 1'b1);
    rst_pin = 1'b0;
    step(1);
  endtask

  task automatic t_idle_irq();
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    chk("R3", "idle cpu", cpu_clk_en, 1'b0);
    chk("R3", "idle per", per_clk_en, 1'b1);
    chk("R3", "idle osc", osc_en, 1'b1);
    step(5);
    chk("R3", "idle stays", cpu_clk_en, 1'b0);
    irq_pend = 1'b1;
    step(1);
    irq_pend = 1'b0;
    chk("R4", "irq wakes cpu", cpu_clk_en, 1'b1);
    chk("R8", "no inhibit on irq wake", ram_wr_inh, 1'b0);
  endtask

  task automatic t_power_down();
    pd_req = 1'b1;
    step(1);
    pd_req = 1'b0;
    chk("R5", "pd cpu", cpu_clk_en, 1'b0);
    chk("R5", "pd per", per_clk_en, 1'b0);
    chk("R5", "pd osc", osc_en, 1'b0);
    irq_pend = 1'b1;
    step(3);
    chk("R5", "irq ignored per", per_clk_en, 1'b0);
    chk("R5", "irq ignored osc", osc_en, 1'b0);
    irq_pend = 1'b0;
    rst_pin = 1'b1;
    #1;
    chk("R6", "osc follows pin", osc_en, 1'b1);
    chk("R6", "cpu gated at pin", cpu_clk_en, 1'b0);
    step(FILT);
    chk("R6", "rst_int at 24", rst_int, 1'b1);
    chk("R6", "per still gated", per_clk_en, 1'b0);
    step(1);
    chk("R6", "cpu after reset", cpu_clk_en, 1'b1);
    chk("R6", "per after reset", per_clk_en, 1'b1);
    rst_pin = 1'b0;
    step(1);
  endtask

  task automatic t_both_requests();
    idle_req = 1'b1;
    pd_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    pd_req = 1'b0;
    chk("R7", "both gives pd per", per_clk_en, 1'b0);
    chk("R7", "both gives pd osc", osc_en, 1'b0);
    pulse_reset();
  endtask

  task automatic t_idle_reset();
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    rst_pin = 1'b1;
    step(1);
    chk("R8", "cpu back on reset wake", cpu_clk_en, 1'b1);
    chk("R8", "inhibit on", ram_wr_inh, 1'b1);
    step(FILT - 2);
    chk("R8", "inhibit at 23", ram_wr_inh, 1'b1);
    chk("R1", "no reset at 23", rst_int, 1'b0);
    step(1);
    chk("R8", "inhibit with reset", ram_wr_inh, 1'b1);
    chk("R1", "reset at 24", rst_int, 1'b1);
    step(1);
    chk("R8", "inhibit ends", ram_wr_inh, 1'b0);
    rst_pin = 1'b0;
    step(1);
  endtask

  task automatic t_idle_short_pin();
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    rst_pin = 1'b1;
    step(5);
    chk("R8", "inhibit during short pin", ram_wr_inh, 1'b1);
    rst_pin = 1'b0;
    step(1);
    chk("R8", "inhibit ends on low", ram_wr_inh, 1'b0);
    chk("R8", "cpu keeps running", cpu_clk_en, 1'b1);
    chk("R2", "no reset on short pin", rst_int, 1'b0);
  endtask

  task automatic t_overlap();
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    rst_pin = 1'b1;
    irq_pend = 1'b1;
    step(1);
    chk("R8", "reset beats irq inhibit", ram_wr_inh, 1'b1);
    chk("R8", "reset beats irq cpu", cpu_clk_en, 1'b1);
    irq_pend = 1'b0;
    rst_pin = 1'b0;
    step(1);
    chk("R8", "overlap cleared", ram_wr_inh, 1'b0);
  endtask

  task automatic t_ea_strap();
    lock1 = 1'b1;
    ea_pin = 1'b1;
    pulse_reset();
    ea_pin = 1'b0;
    #1;
    chk("R9", "locked holds 1", ea_latched, 1'b1);
    lock1 = 1'b0;
    #1;
    chk("R9", "unlocked live", ea_latched, 1'b0);
    lock1 = 1'b1;
    pulse_reset();
    ea_pin = 1'b1;
    #1;
    chk("R9", "locked holds 0", ea_latched, 1'b0);
    lock1 = 1'b0;
    #1;
    chk("R9", "unlocked live 1", ea_latched, 1'b1);
  endtask

  task automatic t_req_in_reset();
    rst_pin = 1'b1;
    step(FILT);
    idle_req = 1'b1;
    step(2);
    chk("R10", "req ignored in reset", cpu_clk_en, 1'b1);
    rst_pin = 1'b0;
    step(2);
    chk("R10", "held level no entry", cpu_clk_en, 1'b1);
    idle_req = 1'b0;
    step(1);
    chk("R10", "still running", cpu_clk_en, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    t_reset_state();
    t_glitch_filter();
    t_idle_irq();
    t_power_down();
    t_both_requests();
    t_idle_reset();
    t_idle_short_pin();
    t_overlap();
    t_ea_strap();
    t_req_in_reset();
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule